// File: doc/BRIEF.md
# SAR Conversion Sequencer with Serial Output

This block is the digital control for a successive-approximation converter. The DAC, comparator, reference and input scaling sit outside it. The block sees only the comparator's decision, as a single input bit. A convert command starts a conversion. The sequencer then walks the result register from the most significant bit down. On each conversion tick it either sets the next bit for trial or settles the bit already under trial. During the conversion it drives a busy status. Each bit is also sent out as an NRZ serial stream, with a one-cycle strobe as each new bit appears.

Conversion ticks come from one of two sources: an internal divider of the system clock, or an external tick input. An inhibit input freezes the tick. A short-cycle control, latched when a conversion starts, stops the conversion after `SHORT_BITS` bits. The parallel result is complemented. In two's-complement mode the MSB is passed through uncomplemented, which gives complementary two's-complement coding for bipolar inputs. Otherwise the coding is complementary straight or offset binary.

Top module: `sar_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `clk_out` and `ser_out` are 0 and the internal result register is zero. `par_out` therefore reads all ones, with the MSB at 0 instead when `twos_mode` is 1.
- R2: A conversion starts on the system clock edge at which `conv_cmd` is first sampled low after being sampled high while idle. `busy` is 1 from that edge on, and the result register is cleared.
- R3: A command is ignored in two cases: its rising edge is sampled while `busy` is 1, or it is never sampled high by a clock edge. In either case the conversion in flight keeps its result and length, and no new conversion starts.
- R4: Bits are resolved from the MSB down. The first tick sets the MSB for trial. Each later tick keeps the bit under trial if `cmp_in` is 1, clears it if `cmp_in` is 0, and sets the next bit for trial. With an ideal comparator (`cmp_in` = trial word <= input), the final `par_out` is the bitwise complement of the input word.
- R5: A conversion of N bits takes N+1 ticks, and `busy` falls on the edge of the last tick. With the internal source, the first tick comes INT_DIV cycles after the start edge and ticks then repeat every INT_DIV cycles. `busy` is therefore high for (N+1)*INT_DIV cycles.
- R6: On each deciding tick, `ser_out` takes the decided bit in true polarity. `clk_out` is high for exactly the one cycle in which that new value first appears. A conversion produces N strobes, MSB first, and `ser_out` changes at no other time except the clear to 0 at start.
- R7: If `short_cycle` is 1 at the start edge, only the top SHORT_BITS bits are resolved and N = SHORT_BITS. The untried low bits stay zero in the result, so they read 1 in `par_out`.
- R8: While `inhibit` is 1, ticks are suppressed and the internal divider holds its count. Each inhibited cycle during a conversion lengthens `busy` by one cycle, and no output changes in that cycle.
- R9: When `ext_sel` is 1, the conversion advances only on cycles with `ext_tick` at 1. The internal divider has no effect in this mode.
- R10: `twos_mode` at 1 leaves bit RES_W-1 of `par_out` uncomplemented. All other bits are always complemented.
- R11: While idle, `par_out` holds its value as long as `twos_mode` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_cmd | input | 1 | Convert command; the conversion starts when it falls |
| cmp_in | input | 1 | Comparator decision, 1 = keep the bit under trial |
| short_cycle | input | 1 | Select reduced resolution (SHORT_BITS) for the next conversion |
| twos_mode | input | 1 | Pass the result MSB through uncomplemented |
| ext_sel | input | 1 | Use ext_tick in place of the internal divider |
| ext_tick | input | 1 | External conversion tick, one system cycle wide |
| inhibit | input | 1 | Freeze the conversion tick |
| busy | output | 1 | Conversion in progress |
| clk_out | output | 1 | Strobe marking a new serial bit |
| ser_out | output | 1 | NRZ serial result, MSB first |
| par_out | output | RES_W | Complement-coded parallel result |

## Verification
The bench goes after the command edge cases. A design that starts on the rising edge, or that re-arms from a command raised during a busy period, would start a stray conversion or restart one already running. The bench also tests tick gating. A design that lets the internal divider run in external mode would finish a stalled conversion, and one that keeps counting under inhibit would end early. Finally, it checks end-of-conversion alignment in both resolutions. An off-by-one on the last index shows up as a wrong `busy` length, a missing final strobe, or stray ones in the low bits of a short-cycle result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } sar_state_e;

   // bits needed to index positions 0 .. n-1
   function automatic int unsigned idx_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sar_cmd_detect.sv
module sar_cmd_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic conv_cmd,
   input  logic busy,
   output logic start
);

   logic cmd_q;
   logic armed;

   // a command counts only if its rising edge is sampled while idle
   assign start = armed & cmd_q & ~conv_cmd & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q <= 1'b0;
         armed <= 1'b0;
      end else begin
         cmd_q <= conv_cmd;
         if (busy || start)
            armed <= 1'b0;
         else if (conv_cmd && !cmd_q)
            armed <= 1'b1;
      end
   end

endmodule

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
   parameter int unsigned INT_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic busy,
   input  logic inhibit,
   input  logic ext_sel,
   input  logic ext_tick,
   output logic tick
);

   localparam int unsigned DIV_W = (INT_DIV < 2) ? 1 : $clog2(INT_DIV);
   localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

   logic [DIV_W-1:0] div_cnt;
   logic             run_int;
   logic             int_hit;

   assign run_int = busy & ~inhibit & ~ext_sel;
   assign int_hit = (div_cnt == DIV_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         div_cnt <= '0;
      else if (start)
         div_cnt <= '0;
      else if (run_int)
         div_cnt <= int_hit ? '0 : div_cnt + 1'b1;
   end

   assign tick = busy & ~inhibit & (ext_sel ? ext_tick : int_hit);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
   import sar_seq_pkg::*;
#(
   parameter int unsigned RES_W      = 12,
   parameter int unsigned SHORT_BITS = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             tick,
   input  logic             cmp_in,
   input  logic             short_cycle,
   output logic             busy,
   output logic [RES_W-1:0] sar,
   output logic             ser_out,
   output logic             strobe
);

   localparam int unsigned   IDX_W      = idx_w(RES_W);
   localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(RES_W - 1);
   localparam logic [IDX_W-1:0] LAST_SHORT = IDX_W'(SHORT_BITS - 1);
   localparam logic [RES_W-1:0] MSB_ONE    = {1'b1, {(RES_W-1){1'b0}}};

   sar_state_e       state;
   logic             trial;
   logic [RES_W-1:0] mask;
   logic [IDX_W-1:0] idx;
   logic [IDX_W-1:0] last_idx;
   logic [RES_W-1:0] settled;

   // bit under trial kept on a 1 decision, dropped on a 0
   assign settled = cmp_in ? sar : (sar & ~mask);
   assign busy    = (state == ST_CONV);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         trial    <= 1'b0;
         mask     <= '0;
         idx      <= '0;
         last_idx <= LAST_FULL;
         sar      <= '0;
         ser_out  <= 1'b0;
         strobe   <= 1'b0;
      end else begin
         strobe <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (start) begin
                  state    <= ST_CONV;
                  trial    <= 1'b0;
                  mask     <= MSB_ONE;
                  idx      <= '0;
                  last_idx <= short_cycle ? LAST_SHORT : LAST_FULL;
                  sar      <= '0;
                  ser_out  <= 1'b0;
               end
            end
            default: begin
               if (tick) begin
                  if (!trial) begin
                     sar   <= sar | mask;
                     trial <= 1'b1;
                  end else begin
                     ser_out <= cmp_in;
                     strobe  <= 1'b1;
                     if (idx == last_idx) begin
                        sar   <= settled;
                        mask  <= '0;
                        trial <= 1'b0;
                        state <= ST_IDLE;
                     end else begin
                        sar  <= settled | (mask >> 1);
                        mask <= mask >> 1;
                        idx  <= idx + 1'b1;
                     end
                  end
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/sar_out_code.sv
module sar_out_code #(
   parameter int unsigned RES_W = 12
) (
   input  logic [RES_W-1:0] sar,
   input  logic             twos_mode,
   output logic [RES_W-1:0] code
);

   for (genvar b = 0; b < RES_W; b++) begin : g_bit
      if (b == RES_W - 1) begin : g_msb
         assign code[b] = twos_mode ? sar[b] : ~sar[b];
      end else begin : g_low
         assign code[b] = ~sar[b];
      end
   end

endmodule

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl #(
   parameter int unsigned RES_W      = 12,
   parameter int unsigned SHORT_BITS = 10,
   parameter int unsigned INT_DIV    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             conv_cmd,
   input  logic             cmp_in,
   input  logic             short_cycle,
   input  logic             twos_mode,
   input  logic             ext_sel,
   input  logic             ext_tick,
   input  logic             inhibit,
   output logic             busy,
   output logic             clk_out,
   output logic             ser_out,
   output logic [RES_W-1:0] par_out
);

   if (RES_W < 2) begin : g_bad_res
      $error("sar_seq_ctrl: RES_W must be at least 2");
   end
   if (SHORT_BITS < 1 || SHORT_BITS >= RES_W) begin : g_bad_short
      $error("sar_seq_ctrl: SHORT_BITS must lie in 1 .. RES_W-1");
   end
   if (INT_DIV < 2) begin : g_bad_div
      $error("sar_seq_ctrl: INT_DIV must be at least 2");
   end

   logic             start;
   logic             tick;
   logic [RES_W-1:0] sar;

   sar_cmd_detect u_cmd (
      .clk      (clk),
      .rst_n    (rst_n),
      .conv_cmd (conv_cmd),
      .busy     (busy),
      .start    (start)
   );

   sar_tick_gen #(
      .INT_DIV (INT_DIV)
   ) u_tick (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .busy     (busy),
      .inhibit  (inhibit),
      .ext_sel  (ext_sel),
      .ext_tick (ext_tick),
      .tick     (tick)
   );

   sar_bit_engine #(
      .RES_W      (RES_W),
      .SHORT_BITS (SHORT_BITS)
   ) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .tick        (tick),
      .cmp_in      (cmp_in),
      .short_cycle (short_cycle),
      .busy        (busy),
      .sar         (sar),
      .ser_out     (ser_out),
      .strobe      (clk_out)
   );

   sar_out_code #(
      .RES_W (RES_W)
   ) u_code (
      .sar       (sar),
      .twos_mode (twos_mode),
      .code      (par_out)
   );

endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
   parameter int unsigned RES_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             conv_cmd,
   input logic             inhibit,
   input logic             twos_mode,
   input logic             busy,
   input logic             clk_out,
   input logic             ser_out,
   input logic [RES_W-1:0] par_out
);

   localparam logic [RES_W-1:0] MSB_ONE = {1'b1, {(RES_W-1){1'b0}}};

   // R2
   start_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (!$past(conv_cmd) && $past(conv_cmd, 2)));

   // R2
   clear_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ((par_out | MSB_ONE) == '1));

   // R6
   strobe_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clk_out |-> (busy || $fell(busy)));

   // R6
   serial_moves_with_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_out) |-> (clk_out || $rose(busy)));

   // R8
   inhibit_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(inhibit) && $past(busy) && $stable(twos_mode)) |-> ($stable(par_out) && !clk_out));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy) && $stable(twos_mode)) |-> $stable(par_out));

endmodule

bind sar_seq_ctrl sar_seq_chk #(.RES_W(RES_W)) u_sar_seq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .conv_cmd  (conv_cmd),
   .inhibit   (inhibit),
   .twos_mode (twos_mode),
   .busy      (busy),
   .clk_out   (clk_out),
   .ser_out   (ser_out),
   .par_out   (par_out)
);

// File: tb/test_sar_seq_ctrl.sv
module test_sar_seq_ctrl;

   localparam int RW  = 12;
   localparam int SB  = 10;
   localparam int DIV = 4;
   localparam logic [RW-1:0] MSB1 = {1'b1, {(RW-1){1'b0}}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic conv_cmd = 1'b0;
   logic short_cycle = 1'b0;
   logic twos_mode = 1'b0;
   logic ext_sel = 1'b0;
   logic ext_tick = 1'b0;
   logic inhibit = 1'b0;
   logic cmp_in;
   logic busy, clk_out, ser_out;
   logic [RW-1:0] par_out;
   logic [RW-1:0] target = '0;
   logic [RW-1:0] trial_word;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   sar_seq_ctrl #(.RES_W(RW), .SHORT_BITS(SB), .INT_DIV(DIV)) i_sar_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .conv_cmd(conv_cmd), .cmp_in(cmp_in),
      .short_cycle(short_cycle), .twos_mode(twos_mode), .ext_sel(ext_sel),
      .ext_tick(ext_tick), .inhibit(inhibit), .busy(busy), .clk_out(clk_out),
      .ser_out(ser_out), .par_out(par_out));

   // ideal comparator acting on the DAC word seen at the parallel port
   assign trial_word = ~par_out ^ (twos_mode ? MSB1 : '0);
   assign cmp_in     = (trial_word <= target);

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [RW-1:0] exp_code(input logic [RW-1:0] t, input bit sh, input bit tw);
      logic [RW-1:0] v;
      v = sh ? {t[RW-1:RW-SB], {(RW-SB){1'b0}}} : t;
      v = ~v;
      if (tw) v[RW-1] = ~v[RW-1];
      return v;
   endfunction

   // cmd_mode: 0 none, 1 short pulse while busy, 2 raised while busy and held past the end
   task automatic run_conv(input logic [RW-1:0] t, input bit sh, input bit tw, input bit ext,
                           input int inh_at, input int inh_len, input int stall,
                           input int cmd_mode, input int cmd_at);
      int nb, nstr, nbits;
      logic [31:0] sbits;
      logic [RW-1:0] idle_val;
      nbits = sh ? SB : RW;
      @(negedge clk);
      target = t; short_cycle = sh; twos_mode = tw; ext_sel = ext;
      conv_cmd = 1'b1;
      @(negedge clk);
      conv_cmd = 1'b0;
      @(negedge clk);
      // R2: busy and cleared result right after the falling edge is sampled
      chk(busy == 1'b1, "R2", "busy after command fall", busy, 1);
      chk(par_out == exp_code('0, 1'b0, tw), "R2", "cleared result", par_out, exp_code('0, 1'b0, tw));
      short_cycle = ~sh;  // R7: latched at start, later changes have no effect
      nb = 0; nstr = 0; sbits = '0;
      forever begin
         if (clk_out) begin
            sbits = {sbits[30:0], ser_out};
            nstr++;
         end
         if (!busy || nb > 2000) break;
         nb++;
         inhibit  = (inh_len > 0) && (nb >= inh_at) && (nb < inh_at + inh_len);
         ext_tick = ext && (nb > stall) && (nb % 3 == 0);
         if (ext && stall > 0 && nb == stall) begin
            // R9: internal divider would have ticked several times by now
            chk(busy == 1'b1, "R9", "stalled without ext_tick", busy, 1);
            chk(par_out == exp_code('0, 1'b0, tw), "R9", "no trial without ext_tick",
                par_out, exp_code('0, 1'b0, tw));
         end
         if (cmd_mode != 0 && nb == cmd_at) conv_cmd = 1'b1;
         if (cmd_mode == 1 && nb == cmd_at + 2) conv_cmd = 1'b0;
         @(negedge clk);
      end
      inhibit = 1'b0; ext_tick = 1'b0;
      // R4 / R7 / R10: final complement-coded word
      chk(par_out == exp_code(t, sh, tw), sh ? "R7" : "R4", "final parallel word",
          par_out, exp_code(t, sh, tw));
      // R6: strobe count and serial bits MSB first
      chk(nstr == nbits, "R6", "strobe count", nstr, nbits);
      chk((sbits & ((32'd1 << nbits) - 1)) == (32'(t) >> (RW - nbits)), "R6", "serial bits",
          sbits & ((32'd1 << nbits) - 1), 32'(t) >> (RW - nbits));
      if (!ext)  // R5 / R8: busy length in cycles
         chk(nb == (nbits + 1) * DIV + inh_len, inh_len > 0 ? "R8" : "R5", "busy cycles",
             nb, (nbits + 1) * DIV + inh_len);
      if (cmd_mode == 2) begin
         @(negedge clk); @(negedge clk);
         conv_cmd = 1'b0;
      end
      // R3 / R11: no restart, idle word stable
      idle_val = par_out;
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R3", "no restart after ignored command", busy, 0);
      chk(par_out == idle_val, "R11", "idle parallel word held", par_out, idle_val);
      conv_cmd = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5A17));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
      chk(clk_out == 1'b0, "R1", "clk_out at reset", clk_out, 0);
      chk(ser_out == 1'b0, "R1", "ser_out at reset", ser_out, 0);
      chk(par_out == '1, "R1", "par_out at reset", par_out, 12'hFFF);

      // R3: pulse that no clock edge samples
      @(negedge clk);
      #1 conv_cmd = 1'b1;
      #2 conv_cmd = 1'b0;
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R3", "sub-cycle command ignored", busy, 0);

      // directed corners
      run_conv(12'h000, 0, 0, 0, 0, 0, 0, 0, 0);     // R4 all zeros
      run_conv(12'hFFF, 0, 0, 0, 0, 0, 0, 0, 0);     // R4 all ones
      run_conv(12'h800, 0, 1, 0, 0, 0, 0, 0, 0);     // R10 MSB pass-through
      run_conv(12'h7FF, 1, 0, 0, 0, 0, 0, 0, 0);     // R7 short cycle
      run_conv(12'hA5C, 1, 1, 0, 0, 0, 0, 0, 0);     // R7 with R10
      run_conv(12'h3C9, 0, 0, 0, 5, 17, 0, 0, 0);    // R8 inhibit
      run_conv(12'h6B1, 0, 0, 1, 0, 0, 30, 0, 0);    // R9 external, stalled first
      run_conv(12'h5D3, 1, 0, 1, 0, 0, 0, 0, 0);     // R9 external, short
      run_conv(12'h2E7, 0, 0, 0, 0, 0, 0, 1, 10);    // R3 pulse while busy
      run_conv(12'h91B, 0, 0, 0, 0, 0, 0, 2, 40);    // R3 held across end

      // constrained random
      for (int i = 0; i < 24; i++) begin
         logic [RW-1:0] t;
         bit sh, tw, ext;
         int il;
         t   = RW'($urandom);
         sh  = ($urandom % 3) == 0;
         tw  = $urandom % 2;
         ext = ($urandom % 4) == 0;
         il  = ($urandom % 2) ? int'($urandom % 12) : 0;
         run_conv(t, sh, tw, ext, 3 + int'($urandom % 8), il, 0, 0, 0);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule